// File: doc/BRIEF.md
# Prioritized External Interrupt Dispatcher

This block decides which pending interrupt a CPU takes next and performs the status-word swap for it. Program-check and supervisor-call requests arrive already decoded on a valid/ready request port. External work comes from three places: a small last-in-first-out queue of posted external entries, a time-of-day comparator event and a CPU-timer event. External sources are only looked at when the current status word enables external interrupts and no program or supervisor-call request is waiting.

Once a source is chosen, the block presents a dispatch record on a valid/ready output port. The record holds the old status word to be saved, with the live condition code inserted, and the interrupt code, parameters, instruction length and CPU address. After the record is accepted, the block loads the new status word for that interrupt class from a save-area register file supplied on its inputs. It reports the loaded condition code and whether the CPU is now halted, has left the running set, or should request a system stop.

Back-pressure: a dispatch record stays on the output unchanged until `out_ready` is seen high while `out_valid` is high. The request port is ready only while the dispatcher is idle, and a request must be held until it is taken. Queue posts and timer events are strobes and are never back-pressured.

Top module: `irq_dispatch`

## Requirements
- R1: After reset, out_valid, load_valid, halted, stop_req, irq_req and ext_overrun are 0, running is 1 and exc_ready is 1.
- R2: A program (exc_svc=0, class 1) or supervisor-call (exc_svc=1, class 2) request is taken ahead of any pending external source; exc_ready is 1 only while idle.
- R3: External sources (class 0) are dispatched only while bit 56 of cur_mask is 1; while it is 0 they stay pending and out_valid stays 0.
- R4: External priority is fixed: queued entry first, then time-of-day (code 0x1004), then CPU timer (code 0x1005); timer dispatches carry zero parameters and clear only their own pending flag.
- R5: The queue holds QDEPTH entries and returns them last-in-first-out; irq_req is 1 exactly while a timer flag is pending or the queue is non-empty.
- R6: A post to a full queue with no pop in the same cycle is dropped and sets ext_overrun, which stays 1 until reset.
- R7: out_old_mask equals cur_mask sampled at selection with bits 14:13 replaced by cur_cc.
- R8: For a supervisor call out_old_addr is cur_addr plus exc_ilc (in bytes); for other classes it is cur_addr. out_cpu_addr is cpu_num OR 0x0D00 for class 0 and 0 otherwise.
- R9: The dispatch record is held stable while out_ready is 0; the cycle after the handshake load_valid is 1 for one cycle with the class's new_mask/new_addr, load_cc equal to its bits 14:13, and no new dispatch is offered before it.
- R10: halted follows bit 49 (wait) of each loaded mask.
- R11: A loaded mask with bit 49 set and bits 57, 56 and 50 all clear sets running to 0, and stop_req to 1 when other_running is 0; both are restored (running 1, stop_req 0) when the next dispatch is selected.
- R12: A timer event or queue post arriving in the cycle a dispatch is selected is kept and dispatched later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_mask | input | 64 | Current status-word mask |
| cur_addr | input | 64 | Current status-word address |
| cur_cc | input | 2 | Live condition code |
| cpu_num | input | 16 | CPU number for the external CPU-address field |
| other_running | input | 1 | Some other CPU is still running |
| tod_evt | input | 1 | Time-of-day comparator event strobe |
| cpt_evt | input | 1 | CPU-timer event strobe |
| push_en | input | 1 | Post an external entry to the queue |
| push_code | input | 16 | Posted interrupt code |
| push_p32 | input | 32 | Posted 32-bit parameter |
| push_p64 | input | 64 | Posted 64-bit parameter |
| exc_valid | input | 1 | Program / supervisor-call request valid |
| exc_ready | output | 1 | Request accepted (idle) |
| exc_svc | input | 1 | 1 = supervisor call, 0 = program check |
| exc_code | input | 16 | Request interrupt code |
| exc_ilc | input | 3 | Instruction length in bytes |
| new_mask | input | 3x64 | New-status-word masks, indexed by class |
| new_addr | input | 3x64 | New-status-word addresses, indexed by class |
| out_valid | output | 1 | Dispatch record valid |
| out_ready | input | 1 | Dispatch record accepted |
| out_class | output | 2 | 0 external, 1 program, 2 supervisor call |
| out_old_mask | output | 64 | Old mask to save |
| out_old_addr | output | 64 | Old address to save |
| out_code | output | 16 | Interrupt code |
| out_ilc | output | 3 | Instruction length (0 for external) |
| out_p32 | output | 32 | 32-bit parameter |
| out_p64 | output | 64 | 64-bit parameter |
| out_cpu_addr | output | 16 | CPU-address field |
| load_valid | output | 1 | New status word loaded this cycle |
| load_mask | output | 64 | Loaded mask |
| load_addr | output | 64 | Loaded address |
| load_cc | output | 2 | Condition code from the loaded mask |
| halted | output | 1 | CPU is in the wait state |
| running | output | 1 | CPU is in the running set |
| stop_req | output | 1 | System stop request |
| irq_req | output | 1 | Some external source is pending |
| ext_overrun | output | 1 | Sticky queue-overflow flag |

## Verification
The assertions assume that a program or supervisor-call request keeps its fields steady until it is taken and that exc_ilc is one of the legal byte lengths; the stimulus raises a request only for the single edge at which the idle dispatcher takes it. They also assume the save-area inputs and cur_mask do not change between a request being taken and the record being accepted. The bench alters these only while no dispatch is in flight. The bench keeps out_ready low except for the one cycle that accepts a record, and drives cur_mask bit 56 low whenever it stages several external sources, so that their order is decided by priority alone.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  localparam int WORD_W = 64;
  localparam int CODE_W = 16;
  localparam int P32_W  = 32;
  localparam int ILC_W  = 3;
  localparam int NCLS   = 3;

  // mask bit positions
  localparam int BIT_IO   = 57;
  localparam int BIT_EXT  = 56;
  localparam int BIT_MCK  = 50;
  localparam int BIT_WAIT = 49;
  localparam int CC_LO    = 13;

  localparam logic [CODE_W-1:0] CODE_TOD     = 16'h1004;
  localparam logic [CODE_W-1:0] CODE_CPT     = 16'h1005;
  localparam logic [CODE_W-1:0] CPU_ADDR_TAG = 16'h0D00;

  typedef enum logic [1:0] {
    CLS_EXT = 2'd0,
    CLS_PGM = 2'd1,
    CLS_SVC = 2'd2
  } irq_cls_e;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [P32_W-1:0]  p32;
    logic [WORD_W-1:0] p64;
  } ext_entry_t;
endpackage

// File: rtl/irq_ext_lifo.sv
module irq_ext_lifo
  import irq_dispatch_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  ext_entry_t push_data,
  input  logic       pop,
  output ext_entry_t top,
  output logic       nonempty,
  output logic       overrun
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0] cnt_q;
  logic          full, pop_ok, wr_ok;
  logic [CW-1:0] wr_idx;
  logic [IW-1:0] top_idx;
  ext_entry_t    slot [DEPTH];

  assign full     = (cnt_q == CW'(DEPTH));
  assign nonempty = (cnt_q != '0);
  assign pop_ok   = pop && nonempty;
  // a pop frees the top slot, so a simultaneous post reuses it
  assign wr_ok    = push && (pop_ok || !full);
  assign wr_idx   = pop_ok ? cnt_q - 1'b1 : cnt_q;
  assign top_idx  = IW'(cnt_q - 1'b1);
  assign top      = nonempty ? slot[top_idx] : '0;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    ext_entry_t e_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                           e_q <= '0;
      else if (wr_ok && wr_idx == CW'(i))   e_q <= push_data;
    end
    assign slot[i] = e_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      overrun <= 1'b0;
    end else begin
      if (wr_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push)  cnt_q <= cnt_q - 1'b1;
      if (push && !pop_ok && full) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_ext_select.sv
module irq_ext_select (
  input  logic q_nonempty,
  input  logic tod_pend,
  input  logic cpt_pend,
  output logic any,
  output logic pick_q,
  output logic pick_tod,
  output logic pick_cpt
);
  // fixed order: queued entry, time-of-day, CPU timer
  assign pick_q   = q_nonempty;
  assign pick_tod = !q_nonempty && tod_pend;
  assign pick_cpt = !q_nonempty && !tod_pend && cpt_pend;
  assign any      = q_nonempty | tod_pend | cpt_pend;
endmodule

// File: rtl/irq_psw_compose.sv
module irq_psw_compose
  import irq_dispatch_pkg::*;
(
  input  logic [WORD_W-1:0] cur_mask,
  input  logic [WORD_W-1:0] cur_addr,
  input  logic [1:0]        cur_cc,
  input  logic              add_ilc,
  input  logic [ILC_W-1:0]  ilc,
  output logic [WORD_W-1:0] old_mask,
  output logic [WORD_W-1:0] old_addr
);
  assign old_mask = {cur_mask[WORD_W-1:CC_LO+2], cur_cc, cur_mask[CC_LO-1:0]};
  assign old_addr = cur_addr + (add_ilc ? WORD_W'(ilc) : '0);
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int QDEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [WORD_W-1:0]          cur_mask,
  input  logic [WORD_W-1:0]          cur_addr,
  input  logic [1:0]                 cur_cc,
  input  logic [CODE_W-1:0]          cpu_num,
  input  logic                       other_running,
  input  logic                       tod_evt,
  input  logic                       cpt_evt,
  input  logic                       push_en,
  input  logic [CODE_W-1:0]          push_code,
  input  logic [P32_W-1:0]           push_p32,
  input  logic [WORD_W-1:0]          push_p64,
  input  logic                       exc_valid,
  output logic                       exc_ready,
  input  logic                       exc_svc,
  input  logic [CODE_W-1:0]          exc_code,
  input  logic [ILC_W-1:0]           exc_ilc,
  input  logic [NCLS-1:0][WORD_W-1:0] new_mask,
  input  logic [NCLS-1:0][WORD_W-1:0] new_addr,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [1:0]                 out_class,
  output logic [WORD_W-1:0]          out_old_mask,
  output logic [WORD_W-1:0]          out_old_addr,
  output logic [CODE_W-1:0]          out_code,
  output logic [ILC_W-1:0]           out_ilc,
  output logic [P32_W-1:0]           out_p32,
  output logic [WORD_W-1:0]          out_p64,
  output logic [CODE_W-1:0]          out_cpu_addr,
  output logic                       load_valid,
  output logic [WORD_W-1:0]          load_mask,
  output logic [WORD_W-1:0]          load_addr,
  output logic [1:0]                 load_cc,
  output logic                       halted,
  output logic                       running,
  output logic                       stop_req,
  output logic                       irq_req,
  output logic                       ext_overrun
);
  typedef enum logic [1:0] {ST_IDLE, ST_OFFER, ST_LOAD} st_e;

  st_e        st_q;
  logic       tod_q, cpt_q;
  logic       q_nonempty, ext_any, pick_q, pick_tod, pick_cpt;
  ext_entry_t q_top, q_in;
  logic       idle, take_exc, take_ext, start;
  logic [WORD_W-1:0] old_mask_w, old_addr_w;

  irq_cls_e          nxt_cls;
  logic [CODE_W-1:0] nxt_code, nxt_cpu;
  logic [ILC_W-1:0]  nxt_ilc;
  logic [P32_W-1:0]  nxt_p32;
  logic [WORD_W-1:0] nxt_p64;

  irq_cls_e          cls_q;
  logic [WORD_W-1:0] sel_mask, sel_addr;
  logic              ld_wait, ld_quiet;

  assign idle     = (st_q == ST_IDLE);
  assign take_exc = idle && exc_valid;
  assign take_ext = idle && !exc_valid && cur_mask[BIT_EXT] && ext_any;
  assign start    = take_exc || take_ext;
  assign q_in     = '{code: push_code, p32: push_p32, p64: push_p64};

  irq_ext_lifo #(.DEPTH(QDEPTH)) u_lifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push_en),
    .push_data(q_in),
    .pop      (take_ext && pick_q),
    .top      (q_top),
    .nonempty (q_nonempty),
    .overrun  (ext_overrun)
  );

  irq_ext_select u_sel (
    .q_nonempty(q_nonempty),
    .tod_pend  (tod_q),
    .cpt_pend  (cpt_q),
    .any       (ext_any),
    .pick_q    (pick_q),
    .pick_tod  (pick_tod),
    .pick_cpt  (pick_cpt)
  );

  irq_psw_compose u_cmp (
    .cur_mask(cur_mask),
    .cur_addr(cur_addr),
    .cur_cc  (cur_cc),
    .add_ilc (exc_valid && exc_svc),
    .ilc     (exc_ilc),
    .old_mask(old_mask_w),
    .old_addr(old_addr_w)
  );

  always_comb begin
    nxt_cls  = CLS_EXT;
    nxt_code = '0;
    nxt_ilc  = '0;
    nxt_p32  = '0;
    nxt_p64  = '0;
    nxt_cpu  = cpu_num | CPU_ADDR_TAG;
    if (exc_valid) begin
      nxt_cls  = exc_svc ? CLS_SVC : CLS_PGM;
      nxt_code = exc_code;
      nxt_ilc  = exc_ilc;
      nxt_cpu  = '0;
    end else if (pick_q) begin
      nxt_code = q_top.code;
      nxt_p32  = q_top.p32;
      nxt_p64  = q_top.p64;
    end else if (pick_tod) begin
      nxt_code = CODE_TOD;
    end else begin
      nxt_code = CODE_CPT;
    end
  end

  always_comb begin
    case (cls_q)
      CLS_PGM: begin sel_mask = new_mask[1]; sel_addr = new_addr[1]; end
      CLS_SVC: begin sel_mask = new_mask[2]; sel_addr = new_addr[2]; end
      default: begin sel_mask = new_mask[0]; sel_addr = new_addr[0]; end
    endcase
  end

  assign ld_wait  = sel_mask[BIT_WAIT];
  assign ld_quiet = !(sel_mask[BIT_IO] || sel_mask[BIT_EXT] || sel_mask[BIT_MCK]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      tod_q        <= 1'b0;
      cpt_q        <= 1'b0;
      cls_q        <= CLS_EXT;
      out_old_mask <= '0;
      out_old_addr <= '0;
      out_code     <= '0;
      out_ilc      <= '0;
      out_p32      <= '0;
      out_p64      <= '0;
      out_cpu_addr <= '0;
      load_mask    <= '0;
      load_addr    <= '0;
      halted       <= 1'b0;
      running      <= 1'b1;
      stop_req     <= 1'b0;
    end else begin
      // new events win over the clear of the source being taken
      tod_q <= tod_evt || (tod_q && !(take_ext && pick_tod));
      cpt_q <= cpt_evt || (cpt_q && !(take_ext && pick_cpt));
      case (st_q)
        ST_IDLE: if (start) begin
          st_q         <= ST_OFFER;
          cls_q        <= nxt_cls;
          out_old_mask <= old_mask_w;
          out_old_addr <= old_addr_w;
          out_code     <= nxt_code;
          out_ilc      <= nxt_ilc;
          out_p32      <= nxt_p32;
          out_p64      <= nxt_p64;
          out_cpu_addr <= nxt_cpu;
          running      <= 1'b1;
          stop_req     <= 1'b0;
        end
        ST_OFFER: if (out_ready) begin
          st_q      <= ST_LOAD;
          load_mask <= sel_mask;
          load_addr <= sel_addr;
          halted    <= ld_wait;
          if (ld_wait && ld_quiet) begin
            running  <= 1'b0;
            stop_req <= !other_running;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign exc_ready  = idle;
  assign out_valid  = (st_q == ST_OFFER);
  assign load_valid = (st_q == ST_LOAD);
  assign out_class  = cls_q;
  assign load_cc    = load_mask[CC_LO+1:CC_LO];
  assign irq_req    = tod_q || cpt_q || q_nonempty;
endmodule

// File: rtl/irq_dispatch_checker.sv
module irq_dispatch_checker
  import irq_dispatch_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] cur_mask,
  input logic [WORD_W-1:0] cur_addr,
  input logic [1:0]        cur_cc,
  input logic              exc_valid,
  input logic              exc_ready,
  input logic [ILC_W-1:0]  exc_ilc,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_class,
  input logic [WORD_W-1:0] out_old_mask,
  input logic [WORD_W-1:0] out_old_addr,
  input logic [CODE_W-1:0] out_code,
  input logic              load_valid,
  input logic              halted,
  input logic              running,
  input logic              stop_req
);
  assert_offer_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_code) && $stable(out_class)
      && $stable(out_old_mask) && $stable(out_old_addr));

  assert_load_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> load_valid && !out_valid);

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> !out_valid && !exc_ready);

  assert_exc_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && exc_ready |=> out_valid && out_class != CLS_EXT);

  assert_ext_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ready && !exc_valid && !cur_mask[BIT_EXT] |=> !out_valid);

  assert_cc_insert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_old_mask[CC_LO+1:CC_LO] == $past(cur_cc));

  assert_svc_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && out_class == CLS_SVC
      |-> out_old_addr == $past(cur_addr) + WORD_W'($past(exc_ilc)));

  assert_stop_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> !running && halted);
endmodule

bind irq_dispatch irq_dispatch_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cur_mask    (cur_mask),
  .cur_addr    (cur_addr),
  .cur_cc      (cur_cc),
  .exc_valid   (exc_valid),
  .exc_ready   (exc_ready),
  .exc_ilc     (exc_ilc),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_class   (out_class),
  .out_old_mask(out_old_mask),
  .out_old_addr(out_old_addr),
  .out_code    (out_code),
  .load_valid  (load_valid),
  .halted      (halted),
  .running     (running),
  .stop_req    (stop_req)
);

// File: tb/irq_dispatch_bench.sv
module irq_dispatch_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] EXT_ON  = 64'h0100_0000_0000_0000;
  localparam logic [63:0] WAIT_B  = 64'h0002_0000_0000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] cur_mask = '0, cur_addr = '0;
  logic [1:0]  cur_cc = '0;
  logic [15:0] cpu_num = 16'h0005;
  logic other_running = 1'b0, tod_evt = 1'b0, cpt_evt = 1'b0, push_en = 1'b0;
  logic [15:0] push_code = '0;
  logic [31:0] push_p32 = '0;
  logic [63:0] push_p64 = '0;
  logic exc_valid = 1'b0, exc_svc = 1'b0;
  logic exc_ready;
  logic [15:0] exc_code = '0;
  logic [2:0]  exc_ilc = '0;
  logic [2:0][63:0] new_mask, new_addr;
  logic out_valid, out_ready = 1'b0;
  logic [1:0]  out_class;
  logic [63:0] out_old_mask, out_old_addr, out_p64, load_mask, load_addr;
  logic [15:0] out_code, out_cpu_addr;
  logic [2:0]  out_ilc;
  logic [31:0] out_p32;
  logic load_valid, halted, running, stop_req, irq_req, ext_overrun;
  logic [1:0] load_cc;

  int checks = 0, fails = 0;
  logic [63:0] g_cls, g_code, g_mask, g_addr, g_cpu, g_ilc, g_p32, g_p64;
  logic [63:0] g_lmask, g_laddr, g_lcc, g_halt, g_run, g_stop;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dispatch u_irq_dispatch (.*);

  task automatic step(); @(negedge clk); endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic take_one(input string tag);
    int n = 0;
    while (!out_valid && n < 30) begin step(); n++; end
    chk({tag, " offer"}, 64'(out_valid), 64'd1);
    g_cls = 64'(out_class); g_code = 64'(out_code); g_mask = out_old_mask;
    g_addr = out_old_addr; g_cpu = 64'(out_cpu_addr); g_ilc = 64'(out_ilc);
    g_p32 = 64'(out_p32); g_p64 = out_p64;
    out_ready = 1'b1;
    step();
    out_ready = 1'b0;
    chk({tag, " R9 load_valid"}, {62'd0, load_valid, out_valid}, 64'd2);
    g_lmask = load_mask; g_laddr = load_addr; g_lcc = 64'(load_cc);
    g_halt = 64'(halted); g_run = 64'(running); g_stop = 64'(stop_req);
    step();
  endtask

  task automatic pulse_tod(); tod_evt = 1'b1; step(); tod_evt = 1'b0; endtask
  task automatic pulse_cpt(); cpt_evt = 1'b1; step(); cpt_evt = 1'b0; endtask
  task automatic post(input logic [15:0] c, input logic [31:0] a, input logic [63:0] b);
    push_en = 1'b1; push_code = c; push_p32 = a; push_p64 = b;
    step();
    push_en = 1'b0;
  endtask
  task automatic request(input logic svc, input logic [15:0] c, input logic [2:0] ilc);
    exc_valid = 1'b1; exc_svc = svc; exc_code = c; exc_ilc = ilc;
    step();
    exc_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 out_valid", 64'(out_valid), 0);
    chk("R1 load_valid", 64'(load_valid), 0);
    chk("R1 flags", {58'd0, halted, stop_req, irq_req, ext_overrun, running, exc_ready}, 64'h3);
  endtask

  task automatic t_program();
    logic [15:0] held;
    cur_mask = 64'h6001; cur_cc = 2'd2; cur_addr = 64'h1000;
    request(1'b0, 16'h0011, 3'd4);
    chk("R9 offered", 64'(out_valid), 1);
    held = out_code;
    step();
    chk("R9 hold valid", 64'(out_valid), 1);
    chk("R9 hold code", 64'(out_code), 64'(held));
    take_one("program");
    chk("R2 class", g_cls, 1);
    chk("R2 code", g_code, 64'h11);
    chk("R7 old mask", g_mask, 64'h4001);
    chk("R8 old addr", g_addr, 64'h1000);
    chk("R8 cpu addr", g_cpu, 0);
    chk("R9 load mask", g_lmask, 64'h2000);
    chk("R9 load addr", g_laddr, 64'h7000);
    chk("R9 load cc", g_lcc, 1);
    chk("R10 not halted", g_halt, 0);
  endtask

  task automatic t_svc();
    cur_mask = 64'h0; cur_cc = 2'd1; cur_addr = 64'h2000;
    request(1'b1, 16'h0030, 3'd2);
    take_one("svc");
    chk("R2 svc class", g_cls, 2);
    chk("R8 svc old addr", g_addr, 64'h2002);
    chk("R7 svc old mask", g_mask, 64'h2000);
    chk("R9 svc load addr", g_laddr, 64'h5000);
    chk("R9 svc load cc", g_lcc, 0);
  endtask

  task automatic t_ext_mask();
    cur_mask = 64'h0;
    pulse_tod();
    repeat (5) step();
    chk("R3 masked no offer", 64'(out_valid), 0);
    chk("R5 irq_req pending", 64'(irq_req), 1);
    cur_mask = EXT_ON;
    take_one("tod");
    chk("R4 tod code", g_code, 64'h1004);
    chk("R4 tod params", g_p32 | g_p64, 0);
    chk("R8 ext cpu addr", g_cpu, 64'h0D05);
    chk("R7 ext old mask", g_mask, EXT_ON | 64'h2000);
    chk("R3 ext class", g_cls, 0);
    chk("R9 ext load cc", g_lcc, 3);
    chk("R5 irq_req clear", 64'(irq_req), 0);
    cur_mask = 64'h0;
  endtask

  task automatic t_priority();
    pulse_cpt();
    pulse_tod();
    post(16'h2401, 32'hAABBCCDD, 64'h1122334455667788);
    cur_mask = EXT_ON;
    take_one("prio1");
    chk("R4 queued first", g_code, 64'h2401);
    chk("R4 queued p32", g_p32, 64'hAABBCCDD);
    chk("R4 queued p64", g_p64, 64'h1122334455667788);
    take_one("prio2");
    chk("R4 tod second", g_code, 64'h1004);
    take_one("prio3");
    chk("R4 cpt third", g_code, 64'h1005);
    chk("R4 cpt params", g_p32 | g_p64, 0);
    chk("R5 irq_req drained", 64'(irq_req), 0);
    cur_mask = 64'h0;
  endtask

  task automatic t_lifo();
    for (int i = 1; i <= 4; i++) post(16'hA000 + 16'(i), 32'(i), 64'(i));
    chk("R6 no overrun at full", 64'(ext_overrun), 0);
    post(16'hA005, 32'd5, 64'd5);
    chk("R6 overrun set", 64'(ext_overrun), 1);
    cur_mask = EXT_ON;
    for (int i = 4; i >= 1; i--) begin
      take_one("lifo");
      chk("R5 lifo order", g_code, 64'(16'hA000 + 16'(i)));
    end
    repeat (4) step();
    chk("R6 dropped entry absent", 64'(out_valid), 0);
    chk("R5 irq_req empty", 64'(irq_req), 0);
    chk("R6 overrun sticky", 64'(ext_overrun), 1);
    cur_mask = 64'h0;
  endtask

  task automatic t_exc_first();
    post(16'hB001, 32'd0, 64'd0);
    cur_mask = EXT_ON;
    request(1'b0, 16'h0022, 3'd6);
    take_one("excfirst");
    chk("R2 exception before queued", g_cls, 1);
    chk("R2 exception code", g_code, 64'h22);
    take_one("excfirst2");
    chk("R2 queued after", g_code, 64'hB001);
    cur_mask = 64'h0;
  endtask

  task automatic t_wait();
    other_running = 1'b0;
    new_mask[2] = WAIT_B;
    request(1'b1, 16'h1, 3'd2);
    take_one("wait1");
    chk("R10 halted", g_halt, 1);
    chk("R11 left running", g_run, 0);
    chk("R11 stop", g_stop, 1);
    request(1'b0, 16'h2, 3'd2);
    chk("R11 running restored", 64'(running), 1);
    chk("R11 stop cleared", 64'(stop_req), 0);
    take_one("wait2");
    chk("R10 halt cleared", g_halt, 0);
    new_mask[2] = WAIT_B | EXT_ON;
    request(1'b1, 16'h3, 3'd2);
    take_one("wait3");
    chk("R10 halted enabled wait", g_halt, 1);
    chk("R11 enabled wait keeps running", g_run | (g_stop << 1), 1);
    new_mask[2] = WAIT_B;
    other_running = 1'b1;
    request(1'b1, 16'h4, 3'd2);
    take_one("wait4");
    chk("R11 others running no stop", g_run | (g_stop << 1), 0);
    new_mask[2] = 64'h0;
    other_running = 1'b0;
  endtask

  task automatic t_noloss();
    pulse_tod();
    cur_mask = EXT_ON; tod_evt = 1'b1;
    step();
    tod_evt = 1'b0;
    take_one("noloss1");
    chk("R12 first tod", g_code, 64'h1004);
    chk("R12 tod kept pending", 64'(irq_req), 1);
    take_one("noloss2");
    chk("R12 second tod", g_code, 64'h1004);
    chk("R12 tod drained", 64'(irq_req), 0);
    cur_mask = 64'h0;
    post(16'hC001, 32'd1, 64'd1);
    cur_mask = EXT_ON;
    post(16'hC002, 32'd2, 64'd2);
    take_one("noloss3");
    chk("R12 popped entry", g_code, 64'hC001);
    take_one("noloss4");
    chk("R12 post during pop kept", g_code, 64'hC002);
    chk("R12 queue drained", 64'(irq_req), 0);
    cur_mask = 64'h0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    new_mask[0] = 64'h6000; new_addr[0] = 64'hE000;
    new_mask[1] = 64'h2000; new_addr[1] = 64'h7000;
    new_mask[2] = 64'h0;    new_addr[2] = 64'h5000;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_program();
    t_svc();
    t_ext_mask();
    t_priority();
    t_lifo();
    t_exc_first();
    t_wait();
    t_noloss();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule